// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block holds the compare output level of one timer channel and decides what an I/O pin shows. The level changes when the counter matches the compare value, when software forces a compare, and at the events that pulse-width modulation needs: the counter reaching bottom, and a match seen while counting down. A two-bit action field `cmp_act` selects the action. The counter's waveform mode decides how that field is read.

The same action field also takes the pin away from the ordinary port. When the field is non-zero, the pin carries the compare level; when it is zero, the pin carries the port data bit. The port direction bit alone decides whether the pin is driven. Software can therefore set the compare level with a forced compare while the pin is still an input, and the first level that appears on the pin is known. The counter, the comparator and any capture logic live outside this block. The action field has no effect on capture.

Top module: `ocpin_unit`

## Requirements
- R1: While `rst_n` is low, `cmp_level` is 0, and it is still 0 on the first cycle after reset is released.
- R2: With `cmp_act` = 2'b00, `cmp_level` keeps its value in every waveform mode, whatever events arrive.
- R3: The `wave_mode` encoding is: 2'b00 and 2'b11 non-PWM, 2'b01 fast PWM, 2'b10 phase-correct PWM. In non-PWM mode a `match` pulse sets `cmp_level` on the next clock edge as follows: `cmp_act` 2'b01 inverts it, 2'b10 makes it 0, 2'b11 makes it 1.
- R4: In non-PWM mode, `force_cmp` applies the same action as a match. When `force_cmp` and `match` arrive in the same cycle, the action is applied once.
- R5: In fast PWM, `cmp_act` 2'b10 makes the level 0 on a match and 1 on `at_bottom`. 2'b11 does the reverse, and 2'b01 takes no action. A match in the same cycle as bottom wins.
- R6: In phase-correct PWM, `cmp_act` 2'b10 makes the level 0 on a match with `count_down` = 0 and 1 on a match with `count_down` = 1. 2'b11 does the reverse, 2'b01 takes no action, and `at_bottom` has no effect.
- R7: In both PWM modes, `force_cmp` has no effect on `cmp_level`.
- R8: `pin_out` equals `cmp_level` when `cmp_act` is non-zero, and `port_out` when `cmp_act` is 2'b00.
- R9: `pin_oe` always equals `port_dir`, whatever `cmp_act` holds. `cmp_level` updates even while `port_dir` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wave_mode | input | 2 | Waveform mode of the counter |
| cmp_act | input | 2 | Compare action / pin takeover field |
| match | input | 1 | Compare match strobe |
| force_cmp | input | 1 | Forced compare strobe |
| at_bottom | input | 1 | Counter at bottom strobe |
| count_down | input | 1 | Counter is counting down |
| port_out | input | 1 | General port data bit |
| port_dir | input | 1 | General port direction bit (1 = output) |
| cmp_level | output | 1 | Internal compare output level |
| pin_out | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The block has no parameters that change its size, so the bench builds it exactly as it is. The bench sweeps every waveform mode and every action field value. For each pair it also tries every combination of the four event inputs, starting from both levels. This covers every simultaneous-event priority and the unused mode code. After each step, the bench walks all four port data and direction combinations, which checks the pin source choice and the output enable across the whole state space.

// File: rtl/ocpin_pkg.sv
package ocpin_pkg;
    localparam int MODE_W = 2;
    localparam int ACT_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        WG_DIRECT = 2'b00,
        WG_FAST   = 2'b01,
        WG_DUAL   = 2'b10,
        WG_ALT    = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef struct packed {
        logic level;
    } oc_reg_t;
endpackage

// File: rtl/ocpin_action.sv
module ocpin_action
    import ocpin_pkg::*;
(
    input  wave_e            mode,
    input  logic [ACT_W-1:0] cmp_act,
    input  logic             match,
    input  logic             force_cmp,
    input  logic             at_bottom,
    input  logic             count_down,
    output act_e             act
);
    always_comb begin
        act = ACT_KEEP;
        unique case (mode)
            WG_FAST: begin
                if (cmp_act[1]) begin
                    if (match)
                        act = cmp_act[0] ? ACT_SET : ACT_CLEAR;
                    else if (at_bottom)
                        act = cmp_act[0] ? ACT_CLEAR : ACT_SET;
                end
            end
            WG_DUAL: begin
                if (cmp_act[1] && match)
                    act = (cmp_act[0] ^ count_down) ? ACT_SET : ACT_CLEAR;
            end
            default: begin
                if (match || force_cmp) begin
                    unique case (cmp_act)
                        2'b01:   act = ACT_TOGGLE;
                        2'b10:   act = ACT_CLEAR;
                        2'b11:   act = ACT_SET;
                        default: act = ACT_KEEP;
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/ocpin_state.sv
module ocpin_state
    import ocpin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act,
    output logic level
);
    oc_reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        unique case (act)
            ACT_TOGGLE: reg_d.level = ~reg_q.level;
            ACT_CLEAR:  reg_d.level = 1'b0;
            ACT_SET:    reg_d.level = 1'b1;
            default:    reg_d = reg_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign level = reg_q.level;

    // R1
    a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !reg_q.level);
    a_r2_keep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_KEEP) |=> (reg_q.level == $past(reg_q.level)));
endmodule

// File: rtl/ocpin_mux.sv
module ocpin_mux
    import ocpin_pkg::*;
(
    input  logic [ACT_W-1:0] cmp_act,
    input  logic             level,
    input  logic             port_out,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe
);
    logic takeover;

    always_comb begin
        takeover = |cmp_act;
        pin_out  = takeover ? level : port_out;
        pin_oe   = port_dir;
    end
endmodule

// File: rtl/ocpin_unit.sv
module ocpin_unit
    import ocpin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] wave_mode,
    input  logic [1:0] cmp_act,
    input  logic       match,
    input  logic       force_cmp,
    input  logic       at_bottom,
    input  logic       count_down,
    input  logic       port_out,
    input  logic       port_dir,
    output logic       cmp_level,
    output logic       pin_out,
    output logic       pin_oe
);
    wave_e mode_e;
    act_e  act;

    assign mode_e = wave_e'(wave_mode);

    ocpin_action u_action (
        .mode       (mode_e),
        .cmp_act    (cmp_act),
        .match      (match),
        .force_cmp  (force_cmp),
        .at_bottom  (at_bottom),
        .count_down (count_down),
        .act        (act)
    );

    ocpin_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .level (cmp_level)
    );

    ocpin_mux u_mux (
        .cmp_act  (cmp_act),
        .level    (cmp_level),
        .port_out (port_out),
        .port_dir (port_dir),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    a_r2_idle_field: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == 2'b00) |=> (cmp_level == $past(cmp_level)));
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((wave_mode == 2'b00 || wave_mode == 2'b11) && cmp_act == 2'b01 && match)
        |=> (cmp_level != $past(cmp_level)));
    a_r4_force_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((wave_mode == 2'b00 || wave_mode == 2'b11) && cmp_act == 2'b11 && force_cmp)
        |=> cmp_level);
    a_r5_bottom_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 2'b01 && cmp_act == 2'b10 && at_bottom && !match) |=> cmp_level);
    a_r6_down_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 2'b10 && cmp_act == 2'b10 && match && count_down) |=> cmp_level);
    a_r7_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((wave_mode == 2'b01 || wave_mode == 2'b10) && !match && !at_bottom)
        |=> (cmp_level == $past(cmp_level)));
    a_r8_port_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == 2'b00) |-> (pin_out == port_out));
    a_r9_dir_only: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == port_dir);
endmodule

// File: tb/tb_ocpin_unit.sv
module tb_ocpin_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wave_mode = '0;
    logic [1:0] cmp_act = '0;
    logic       match = 1'b0, force_cmp = 1'b0, at_bottom = 1'b0, count_down = 1'b0;
    logic       port_out = 1'b0, port_dir = 1'b0;
    logic       cmp_level, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocpin_unit dut (
        .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .cmp_act(cmp_act),
        .match(match), .force_cmp(force_cmp), .at_bottom(at_bottom),
        .count_down(count_down), .port_out(port_out), .port_dir(port_dir),
        .cmp_level(cmp_level), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic act_v, input logic exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (mode %0d act %0d m%b f%b b%b d%b)",
                     req, act_v, exp_v, wave_mode, cmp_act, match, force_cmp,
                     at_bottom, count_down);
        end
    endtask

    // Expected next level and the requirement that governs it.
    function automatic logic model_next(input int md, input int a, input bit m,
                                        input bit f, input bit b, input bit d,
                                        input logic s);
        int hi = a / 2;
        int lo = a % 2;
        if (a == 0) return s;
        if (md == 1) begin
            if (hi == 0) return s;
            if (m) return logic'(lo);
            if (b) return logic'(1 - lo);
            return s;
        end
        if (md == 2) begin
            if (hi == 0 || !m) return s;
            return logic'((lo + int'(d)) % 2);
        end
        if (!(m || f)) return s;
        if (a == 1) return ~s;
        return logic'(lo);
    endfunction

    function automatic string req_of(input int md, input int a, input bit m, input bit f);
        if (a == 0) return "R2";
        if (md == 1) return f ? "R7/R5" : "R5";
        if (md == 2) return f ? "R7/R6" : "R6";
        if (f) return "R4";
        return "R3";
    endfunction

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", cmp_level, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", cmp_level, 1'b0);

        for (int md = 0; md < 4; md++) begin
            for (int a = 0; a < 4; a++) begin
                for (int init = 0; init < 2; init++) begin
                    for (int ev = 0; ev < 16; ev++) begin
                        logic expv;
                        bit m, f, b, d;
                        // preset the level with a forced compare in non-PWM mode, pin as input
                        @(negedge clk);
                        wave_mode = 2'b00; cmp_act = init ? 2'b11 : 2'b10;
                        match = 0; force_cmp = 1; at_bottom = 0; count_down = 0;
                        port_dir = 0;
                        @(negedge clk);
                        force_cmp = 0;
                        check("R9", cmp_level, logic'(init));
                        check("R9", pin_oe, 1'b0);
                        m = ev[0]; f = ev[1]; b = ev[2]; d = ev[3];
                        wave_mode = 2'(md); cmp_act = 2'(a);
                        match = m; force_cmp = f; at_bottom = b; count_down = d;
                        expv = model_next(md, a, m, f, b, d, logic'(init));
                        @(negedge clk);
                        match = 0; force_cmp = 0; at_bottom = 0; count_down = 0;
                        check(req_of(md, a, m, f), cmp_level, expv);
                        for (int p = 0; p < 4; p++) begin
                            port_out = p[0]; port_dir = p[1];
                            #1;
                            check("R8", pin_out, (a != 0) ? expv : logic'(p[0]));
                            check("R9", pin_oe, logic'(p[1]));
                        end
                    end
                end
            end
        end

        // reset again mid-run, level must drop
        @(negedge clk);
        wave_mode = 2'b00; cmp_act = 2'b11; force_cmp = 1;
        @(negedge clk);
        force_cmp = 0;
        rst_n = 0;
        #1;
        check("R1", cmp_level, 1'b0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", cmp_level, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule